// File: doc/BRIEF.md
# Grouped GPIO Interrupt Service Encoder

This block collects up to sixteen external interrupt lines per group, for a parameterised number of groups. Each line passes through a two-flop synchroniser. It is then tested against a trigger mode that it shares with three neighbouring lines. A detected event is latched into a pending bit. A pending bit that is not masked drives a single combined interrupt output. Configuration, mask and pending state sit in 32-bit words, and each word carries two groups, one in each half.

A read-only service word names one pending, unmasked source as a group number and a line number, with the lowest group and then the lowest line winning. The reported group is the storage group index plus one, so a group field of zero means nothing is waiting. Software reads the service word, handles the named source, clears its pending bit, and reads again until the group field is zero. Reported group 1 is shared by two banks of eight lines: lines 8 to 15 are the second bank's lines 0 to 7, and software splits them.

The register port is a plain write strobe with a combinational read.

Top module: `gpio_irq_svc`

## Requirements
- R1: Storage group g occupies bits 16*(g mod 2) to 16*(g mod 2)+15 of the word at byte offset 4*(g/2), above the bases 0x200 (trigger), 0x240 (mask) and 0x260 (pending). Trigger and mask words read back what was written. Bits with no line behind them read 0 and ignore writes.
- R2: Each run of four lines shares one 4-bit trigger field at bit 4*(b/4) of the word, where b is the line's bit index in that word. The codes are 0 for low level, 1 for high level, 2 for falling edge, 4 for rising edge and 6 for both edges.
- R3: An edge trigger sets pending once per matching edge and not again while the line holds its level. A level trigger sets pending on every cycle that the level is active.
- R4: A mask bit of 1 blocks its line from the output and from the service word. The pending bit is still recorded.
- R5: Writing 1 to a pending bit clears it, and writing 0 has no effect. A new event in the same cycle wins over the clear.
- R6: The service word at 0x284 is read-only. Bits [7:4] hold storage group + 1 and bits [3:0] hold the line. It reads 0 when no unmasked source is pending.
- R7: The service word reports the lowest unmasked pending group, and within that group the lowest line.
- R8: The service word shows the next source, or 0, on the first read after the clock edge that takes the pending clear.
- R9: `irq_out` is high exactly while some line is pending and unmasked. Bit 0 of the word at 0x288 reads the same value.
- R10: After reset all trigger fields are 0, all valid lines are masked, nothing is pending, and the output and service word are 0.
- R11: A change on an input line sets its pending bit on the third rising clock edge after the change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_lines | input | NGRP*16 | External interrupt lines, line 16*g+k is line k of group g |
| bus_we | input | 1 | Write strobe for the word at bus_addr |
| bus_addr | input | AW | Byte address of the register word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| irq_out | output | 1 | Combined interrupt, any unmasked pending source |

## Verification
Every trigger code is applied to lines that fall, rise and then hold. This separates edge detection from level detection, and it shows the level re-set that beats a clear in the same cycle. Three unmasked sources in different groups and both word halves are raised together with a masked source in a lower position. Walking the service word through them shows the priority order, the group-plus-one encoding and the same-cycle update after each clear. A single line toggled after quiet cycles fixes the synchroniser latency, and the combined output is compared against a behavioural model on every clock.

// File: rtl/gpio_irq_svc.sv
module gpio_irq_svc #(
  parameter int NGRP = 9,
  parameter int AW   = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NGRP*16-1:0] ext_lines,
  input  logic              bus_we,
  input  logic [AW-1:0]     bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              irq_out
);
  localparam int NL = NGRP * 16;
  localparam int NW = (NGRP + 1) / 2;
  localparam int NP = NW * 32;
  localparam int IW = $clog2(NP);
  localparam logic [NP-1:0] VALID = NP'({NL{1'b1}});
  localparam logic [AW-1:0] A_CFG = AW'(12'h200);
  localparam logic [AW-1:0] A_MSK = AW'(12'h240);
  localparam logic [AW-1:0] A_PND = AW'(12'h260);
  localparam logic [AW-1:0] A_SVC = AW'(12'h284);
  localparam logic [AW-1:0] A_SVP = AW'(12'h288);

  logic [NL-1:0] sy1, sy2, prv, set_v;
  logic [NP-1:0] cfg_q, msk_q, pnd_q, clr_v, act;
  logic [IW-1:0] win;
  logic          any;
  logic [3:0]    sgrp, sline;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sy1 <= '0;
      sy2 <= '0;
      prv <= '0;
    end else begin
      sy1 <= ext_lines;
      sy2 <= sy1;
      prv <= sy2;
    end

  for (genvar i = 0; i < NL; i++) begin : g_line
    logic [2:0] trig;
    assign trig = cfg_q[4*(i/4) +: 3];
    assign set_v[i] = (trig[2:1] == 2'b00) ? (sy2[i] == trig[0])
                    : ((trig[2] & sy2[i] & ~prv[i]) | (trig[1] & ~sy2[i] & prv[i]));
  end

  always_comb begin
    clr_v = '0;
    for (int w = 0; w < NW; w++)
      if (bus_we && bus_addr == A_PND + AW'(4*w)) clr_v[w*32 +: 32] = bus_wdata;
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      cfg_q <= '0;
      msk_q <= VALID;
      pnd_q <= '0;
    end else begin
      for (int w = 0; w < NW; w++) begin
        if (bus_we && bus_addr == A_CFG + AW'(4*w)) cfg_q[w*32 +: 32] <= bus_wdata & VALID[w*32 +: 32];
        if (bus_we && bus_addr == A_MSK + AW'(4*w)) msk_q[w*32 +: 32] <= bus_wdata & VALID[w*32 +: 32];
      end
      pnd_q <= ((pnd_q & ~clr_v) | NP'(set_v)) & VALID;
    end

  assign act = pnd_q & ~msk_q;

  always_comb begin
    win = '0;
    any = 1'b0;
    for (int i = NL - 1; i >= 0; i--)
      if (act[i]) begin
        win = IW'(i);
        any = 1'b1;
      end
  end

  assign irq_out = |act;
  assign sgrp    = any ? 4'(win[IW-1:4]) + 4'd1 : 4'd0;
  assign sline   = any ? win[3:0] : 4'd0;

  always_comb begin
    bus_rdata = '0;
    for (int w = 0; w < NW; w++) begin
      if (bus_addr == A_CFG + AW'(4*w)) bus_rdata = cfg_q[w*32 +: 32];
      if (bus_addr == A_MSK + AW'(4*w)) bus_rdata = msk_q[w*32 +: 32];
      if (bus_addr == A_PND + AW'(4*w)) bus_rdata = pnd_q[w*32 +: 32];
    end
    if (bus_addr == A_SVC) bus_rdata = {24'd0, sgrp, sline};
    if (bus_addr == A_SVP) bus_rdata = {31'd0, irq_out};
  end

  AST_CFG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_we |=> ($stable(cfg_q) && $stable(msk_q))); // R1
  AST_NO_SPURIOUS_PEND: assert property (@(posedge clk) disable iff (!rst_n)
    ((pnd_q & ~$past(pnd_q)) & ~$past(NP'(set_v))) == '0); // R3
  AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (|(clr_v & ~NP'(set_v))) |=> ((pnd_q & $past(clr_v & ~NP'(set_v))) == '0)); // R5
  AST_IRQ_SVC_AGREE: assert property (@(posedge clk) disable iff (!rst_n)
    irq_out == (sgrp != 4'd0)); // R6
  AST_LOWEST_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    any |-> (act[win] && ((act & ((NP'(1) << win) - NP'(1))) == '0))); // R7
endmodule

// File: tb/sim_gpio_irq_svc.sv
module sim_gpio_irq_svc;
  localparam int CLK_NS = 10;
  localparam int NGRP = 9;
  localparam int NL = NGRP * 16;
  localparam int NW = (NGRP + 1) / 2;
  localparam int NP = NW * 32;
  localparam bit [NP-1:0] VAL = NP'({NL{1'b1}});

  logic clk = 1'b0, rst_n = 1'b0, we = 1'b0;
  logic [NL-1:0] lines = '1;
  logic [11:0] addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic irq;
  int errs = 0, checks = 0;

  always #(CLK_NS/2) clk = ~clk;

  gpio_irq_svc #(.NGRP(NGRP), .AW(12)) u0 (
    .clk(clk), .rst_n(rst_n), .ext_lines(lines), .bus_we(we),
    .bus_addr(addr), .bus_wdata(wdata), .bus_rdata(rdata), .irq_out(irq));

  bit [NP-1:0] m_cfg, m_msk, m_pnd;
  bit [NL-1:0] m_s1, m_s2, m_pv;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cfg = '0; m_msk = VAL; m_pnd = '0; m_s1 = '0; m_s2 = '0; m_pv = '0;
    end else begin
      bit [NP-1:0] nx;
      nx = m_pnd;
      for (int w = 0; w < NW; w++)
        if (we && addr == 12'(32'h260 + 4*w)) nx = nx & ~(NP'(wdata) << (32*w));
      for (int i = 0; i < NL; i++) begin
        int t;
        bit hit;
        t = int'(m_cfg[4*(i/4) +: 4]) & 7;
        case (t)
          0: hit = !m_s2[i];
          1: hit = m_s2[i];
          default: hit = ((t & 4) != 0 && m_s2[i] && !m_pv[i]) || ((t & 2) != 0 && !m_s2[i] && m_pv[i]);
        endcase
        if (hit) nx[i] = 1'b1;
      end
      for (int w = 0; w < NW; w++) begin
        if (we && addr == 12'(32'h200 + 4*w)) m_cfg[32*w +: 32] = wdata & VAL[32*w +: 32];
        if (we && addr == 12'(32'h240 + 4*w)) m_msk[32*w +: 32] = wdata & VAL[32*w +: 32];
      end
      m_pnd = nx & VAL;
      m_pv = m_s2; m_s2 = m_s1; m_s1 = lines;
    end
  end

  function automatic bit [31:0] m_svc();
    for (int i = 0; i < NL; i++)
      if (m_pnd[i] && !m_msk[i]) return 32'((i/16 + 1)*16 + i%16);
    return 32'd0;
  endfunction

  function automatic bit [31:0] m_rd(input int a);
    for (int w = 0; w < NW; w++) begin
      if (a == 32'h200 + 4*w) return m_cfg[32*w +: 32];
      if (a == 32'h240 + 4*w) return m_msk[32*w +: 32];
      if (a == 32'h260 + 4*w) return m_pnd[32*w +: 32];
    end
    if (a == 32'h284) return m_svc();
    if (a == 32'h288) return {31'd0, |(m_pnd & ~m_msk)};
    return 32'd0;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  always @(negedge clk)
    if (rst_n) chk(irq === |(m_pnd & ~m_msk), "R9 irq vs model", 32'(irq), 32'(|(m_pnd & ~m_msk)));

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    addr = 12'(a); wdata = d; we = 1'b1;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rdexp(input int a, input logic [31:0] exp, input string tag);
    addr = 12'(a); we = 1'b0;
    #1;
    chk(rdata === exp, tag, rdata, exp);
    chk(rdata === m_rd(a), {tag, " model"}, rdata, m_rd(a));
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  endtask

  initial begin
    #(CLK_NS * 200000);
    errs++; checks++;
    $display("FAIL watchdog: got timeout expected completion");
    summary();
  end

  initial begin
    step(2);
    rdexp(32'h200, 32'h0, "R10 trigger reset");
    rdexp(32'h240, 32'hFFFF_FFFF, "R10 mask reset");
    rdexp(32'h250, 32'h0000_FFFF, "R10 mask reset last word");
    rdexp(32'h260, 32'h0, "R10 pending reset");
    rdexp(32'h284, 32'h0, "R10 service reset");
    rdexp(32'h288, 32'h0, "R10 output reset");
    chk(irq === 1'b0, "R10 irq reset", 32'(irq), 32'h0);
    rst_n = 1'b1;
    step(4);
    for (int w = 0; w < NW; w++) wr(32'h260 + 4*w, 32'hFFFF_FFFF);
    rdexp(32'h260, 32'h0, "R5 cleared after start");

    // R11 latency and rising edge on line 2
    wr(32'h200, 32'h4);
    wr(32'h240, ~32'h4);
    lines[2] = 1'b0;
    step(4);
    rdexp(32'h260, 32'h0, "R2 falling ignored by rising code");
    lines[2] = 1'b1;
    step(1); chk(irq === 1'b0, "R11 edge 1", 32'(irq), 32'h0);
    step(1); chk(irq === 1'b0, "R11 edge 2", 32'(irq), 32'h0);
    step(1); chk(irq === 1'b1, "R11 edge 3", 32'(irq), 32'h1);
    rdexp(32'h284, 32'h12, "R6 service group 1 line 2");
    step(3);
    wr(32'h260, 32'h4);
    rdexp(32'h284, 32'h0, "R8 service idle after clear");
    step(3);
    rdexp(32'h260, 32'h0, "R3 held high no re-trigger");

    // R2 R3 R4 R5 every trigger code on storage groups 4 and 5, all masked
    wr(32'h208, 32'h0006_4210);
    step(4);
    wr(32'h268, 32'hFFFF_FFFF);
    rdexp(32'h268, 32'h0000_00F0, "R5 high level wins over clear");
    lines[64] = 1'b0; lines[68] = 1'b0; lines[72] = 1'b0; lines[76] = 1'b0; lines[80] = 1'b0;
    step(4);
    rdexp(32'h268, 32'h0001_01F1, "R2 low level, falling, both on fall");
    chk(irq === 1'b0, "R4 masked lines keep irq low", 32'(irq), 32'h0);
    rdexp(32'h284, 32'h0, "R4 masked lines not serviced");
    wr(32'h268, 32'hFFFF_FFFF);
    rdexp(32'h268, 32'h0000_00E1, "R3 level sources set again");
    lines[64] = 1'b1; lines[68] = 1'b1; lines[72] = 1'b1; lines[76] = 1'b1; lines[80] = 1'b1;
    step(4);
    rdexp(32'h268, 32'h0001_10F1, "R2 rising, both, high on rise");
    wr(32'h268, 32'h0);
    rdexp(32'h268, 32'h0001_10F1, "R5 zero write no effect");
    wr(32'h268, 32'hFFFF_FFFF);
    rdexp(32'h268, 32'h0000_00F0, "R3 edges gone, level stays");
    wr(32'h208, 32'h0);
    wr(32'h268, 32'hFFFF_FFFF);
    rdexp(32'h268, 32'h0, "R3 inactive level no set");

    // R6 R7 R8 priority walk
    wr(32'h200, 32'h0004_0404);
    wr(32'h210, 32'h0000_4000);
    wr(32'h240, ~32'h0001_0200);
    wr(32'h250, ~32'h0000_8000);
    lines[3] = 1'b0; lines[9] = 1'b0; lines[16] = 1'b0; lines[143] = 1'b0;
    step(4);
    lines[3] = 1'b1; lines[9] = 1'b1; lines[16] = 1'b1; lines[143] = 1'b1;
    step(4);
    rdexp(32'h260, 32'h0001_0208, "R1 both halves of word 0");
    rdexp(32'h270, 32'h0000_8000, "R1 group 8 lower half");
    rdexp(32'h284, 32'h19, "R7 lowest group first");
    rdexp(32'h288, 32'h1, "R9 output readback high");
    wr(32'h260, 32'h200);
    rdexp(32'h284, 32'h20, "R8 next source group 2");
    wr(32'h260, 32'h1_0000);
    rdexp(32'h284, 32'h9F, "R6 group 9 line 15");
    wr(32'h270, 32'h8000);
    rdexp(32'h284, 32'h0, "R8 idle after last clear");
    rdexp(32'h288, 32'h0, "R9 output readback low");
    rdexp(32'h260, 32'h0000_0008, "R4 masked pending kept");
    wr(32'h260, 32'h8);

    // R1 layout and read-only words
    wr(32'h210, 32'hFFFF_FFFF);
    rdexp(32'h210, 32'h0000_FFFF, "R1 unused half reads zero");
    wr(32'h210, 32'h0);
    wr(32'h24C, 32'h1234_5678);
    rdexp(32'h24C, 32'h1234_5678, "R1 mask readback");
    wr(32'h24C, 32'hFFFF_FFFF);
    wr(32'h284, 32'hFFFF_FFFF);
    rdexp(32'h284, 32'h0, "R6 service ignores writes");
    step(4);
    summary();
  end
endmodule